// File: doc/BRIEF.md
# Cascadable Regular-Expression Element Cell

This block is one element of a linear chain that recognises a regular expression in a byte stream. Each cell watches a single character-hit line, which an outside character decoder drives high when the current byte is the character this cell stands for. The cell applies a quantifier to that character, and it registers its own match. It hands an enable forward to the next cell in the chain. The first cell of a chain has its prefix input tied high, so a match attempt can begin on any byte. Every other cell takes its prefix from the cell before it.

At run time a small configuration word picks the operator. The choices are plain sequence, alternation with the following cell, zero-or-more, one-or-more, zero-or-one, and counted repetition with four kinds of bound. Two flags mark the cell as the first or last member of a single-level group. The configuration is captured only while the idle strobe is high, and that strobe also clears the match state. A cell therefore never runs on a half-written setting. A group's last cell drives a backward loop line through the interior cells to the group's first cell, so that the group can start again after it completes. Counted repetition uses a saturating counter inside the cell and a range decoder that compares the count with the configured bounds.

Top module: `rx_elem_cell`

## Requirements
- R1: After reset, and in the cycle after any cycle with `idle_i` high, `match_o` and `alt_o` are 0. After reset the configuration is plain sequence with both group flags clear.
- R2: With operator code 0 (sequence), `match_o` is 1 in the cycle after a cycle in which `hit_i` and the enable are both 1, and 0 otherwise. The enable is `pfx_i`, or `loop_i` when the group-start flag is set. A hit without an enable gives no match.
- R3: With operator code 3 (one-or-more), once the cell has matched, each further consecutive hit keeps `match_o` high without a prefix. The first miss drops `match_o` in the next cycle.
- R4: With operator code 2 (zero-or-more), the cell extends itself as in R3. In the same cycle, `pfx_o` is 1 whenever `pfx_i` is 1, even when the cell has not matched.
- R5: With operator code 4 (zero-or-one), a hit matches only with an enable, so there is no self-extension. `pfx_o` also carries `pfx_i` through in the same cycle.
- R6: With operator code 1 (alternation), `pfx_o` equals `pfx_i`, so the next cell tries the same position, and `alt_o` carries this cell's registered match. In a cell of any other operator, `alt_i` high makes `pfx_o` high.
- R7: With operator code 5 (repetition), an enabled hit increments an 8-bit count. Once the count is nonzero it keeps itself enabled. Any miss clears the count synchronously, and the count saturates at 255 and does not wrap.
- R8: In repetition mode, `match_o` is 1 in the cycle after a counted hit whose new count lies in range. The bound kind `cfg_rk_i` selects the range: 0 means count equals `cfg_lo_i`, 1 means count at least `cfg_lo_i`, 2 means count from 1 to `cfg_hi_i`, and 3 means count from `cfg_lo_i` to `cfg_hi_i`. When zero repetitions are allowed (kind 2, or a lower bound of 0), `pfx_i` passes to `pfx_o` in the same cycle.
- R9: The group-start cell accepts `loop_i` as an enable and drives `loop_o` low. The group-end cell drives `loop_o` equal to `match_o`. Any other cell passes `loop_i` to `loop_o`.
- R10: Changes on the configuration inputs while `idle_i` is low have no effect on the cell's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Idle strobe: clears state and loads configuration |
| hit_i | input | 1 | Current byte is this cell's character |
| pfx_i | input | 1 | Prefix enable from previous cell |
| loop_i | input | 1 | Backward group loop from next cell |
| alt_i | input | 1 | Alternation match from previous cell |
| cfg_op_i | input | 3 | Operator code |
| cfg_gs_i | input | 1 | Group-start flag |
| cfg_ge_i | input | 1 | Group-end flag |
| cfg_rk_i | input | 2 | Repetition bound kind |
| cfg_lo_i | input | CW | Lower repetition bound |
| cfg_hi_i | input | CW | Upper repetition bound |
| match_o | output | 1 | Registered match of this cell |
| pfx_o | output | 1 | Prefix enable to next cell |
| alt_o | output | 1 | Alternation match to next cell |
| loop_o | output | 1 | Backward group loop to previous cell |

## Verification
`match_o`, `alt_o` and the repetition count update on the first rising edge after the inputs that cause them. The bench therefore drives each input pattern on a falling edge and checks these results on the next falling edge. `pfx_o` and `loop_o` follow their inputs within the same cycle. The bench checks them one time unit after it drives the inputs, before any clock edge. Repetition cases count edges one by one, including the 255-hit run that shows saturation.

// File: rtl/rx_cell_pkg.sv
package rx_cell_pkg;

   typedef enum logic [2:0] {
      OP_CAT  = 3'd0,
      OP_ALT  = 3'd1,
      OP_STAR = 3'd2,
      OP_PLUS = 3'd3,
      OP_OPT  = 3'd4,
      OP_REP  = 3'd5
   } op_e;

   typedef enum logic [1:0] {
      RK_EXACT   = 2'd0,
      RK_ATLEAST = 2'd1,
      RK_ATMOST  = 2'd2,
      RK_BETWEEN = 2'd3
   } rk_e;

   typedef struct packed {
      op_e  op;
      logic gs;
      logic ge;
      rk_e  rk;
   } cell_mode_t;

   localparam cell_mode_t MODE_RESET = '{op: OP_CAT, gs: 1'b0, ge: 1'b0, rk: RK_EXACT};

endpackage

// File: rtl/rx_cfg_hold.sv
module rx_cfg_hold
   import rx_cell_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  cell_mode_t       mode_i,
   input  logic [CW-1:0]    lo_i,
   input  logic [CW-1:0]    hi_i,
   output cell_mode_t       mode_q,
   output logic [CW-1:0]    lo_q,
   output logic [CW-1:0]    hi_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         lo_q   <= '0;
         hi_q   <= '0;
      end else if (load) begin
         mode_q <= mode_i;
         lo_q   <= lo_i;
         hi_q   <= hi_i;
      end
   end

endmodule

// File: rtl/rx_rep_cnt.sv
module rx_rep_cnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          hit,
   input  logic          step,
   output logic [CW-1:0] cnt_nx,
   output logic [CW-1:0] cnt_q
);

   localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

   always_comb begin
      if (!hit)
         cnt_nx = '0;
      else if (step)
         cnt_nx = (cnt_q == CNT_TOP) ? CNT_TOP : cnt_q + 1'b1;
      else
         cnt_nx = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else
         cnt_q <= cnt_nx;
   end

endmodule

// File: rtl/rx_rng_dec.sv
module rx_rng_dec
   import rx_cell_pkg::*;
#(
   parameter int CW = 8
) (
   input  rk_e           rk,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] lo,
   input  logic [CW-1:0] hi,
   output logic          in_rng,
   output logic          zero_ok
);

   logic ge_lo, le_hi, nz;

   always_comb begin
      ge_lo = (cnt >= lo);
      le_hi = (cnt <= hi);
      nz    = (cnt != '0);
      unique case (rk)
         RK_EXACT:   in_rng = (cnt == lo);
         RK_ATLEAST: in_rng = ge_lo && nz;
         RK_ATMOST:  in_rng = le_hi && nz;
         default:    in_rng = ge_lo && le_hi && nz;
      endcase
      zero_ok = (rk == RK_ATMOST) || ((rk != RK_EXACT) && (lo == '0));
   end

endmodule

// File: rtl/rx_elem_cell.sv
module rx_elem_cell
   import rx_cell_pkg::*;
#(
   parameter int CW      = 8,
   parameter bit HAS_REP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idle_i,
   input  logic          hit_i,
   input  logic          pfx_i,
   input  logic          loop_i,
   input  logic          alt_i,
   input  logic [2:0]    cfg_op_i,
   input  logic          cfg_gs_i,
   input  logic          cfg_ge_i,
   input  logic [1:0]    cfg_rk_i,
   input  logic [CW-1:0] cfg_lo_i,
   input  logic [CW-1:0] cfg_hi_i,
   output logic          match_o,
   output logic          pfx_o,
   output logic          alt_o,
   output logic          loop_o
);

   initial begin
      assert (CW >= 2 && CW <= 16)
         else $error("rx_elem_cell: CW must lie in 2..16");
   end

   cell_mode_t    mode_in, mode_q;
   logic [CW-1:0] lo_q, hi_q;
   logic [CW-1:0] cnt_q, cnt_nx;
   logic          rng_ok, zero_ok;
   logic          self_en, en, step, match_d, match_q, bypass;

   assign mode_in = '{op: op_e'(cfg_op_i), gs: cfg_gs_i, ge: cfg_ge_i, rk: rk_e'(cfg_rk_i)};

   rx_cfg_hold #(.CW(CW)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (idle_i),
      .mode_i (mode_in),
      .lo_i   (cfg_lo_i),
      .hi_i   (cfg_hi_i),
      .mode_q (mode_q),
      .lo_q   (lo_q),
      .hi_q   (hi_q)
   );

   generate
      if (HAS_REP) begin : g_rep
         logic rep_step;
         assign rep_step = step && (mode_q.op == OP_REP);
         rx_rep_cnt #(.CW(CW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (idle_i),
            .hit    (hit_i),
            .step   (rep_step),
            .cnt_nx (cnt_nx),
            .cnt_q  (cnt_q)
         );
         rx_rng_dec #(.CW(CW)) u_rng (
            .rk      (mode_q.rk),
            .cnt     (cnt_nx),
            .lo      (lo_q),
            .hi      (hi_q),
            .in_rng  (rng_ok),
            .zero_ok (zero_ok)
         );
      end else begin : g_norep
         assign cnt_q   = '0;
         assign cnt_nx  = '0;
         assign rng_ok  = 1'b0;
         assign zero_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (mode_q.op)
         OP_PLUS, OP_STAR: self_en = match_q;
         OP_REP:           self_en = (cnt_q != '0);
         default:          self_en = 1'b0;
      endcase
      en   = pfx_i || (mode_q.gs && loop_i) || self_en;
      step = hit_i && en;
      if (mode_q.op == OP_REP)
         match_d = step && rng_ok;
      else
         match_d = step;
      bypass = (mode_q.op == OP_STAR) || (mode_q.op == OP_OPT) ||
               ((mode_q.op == OP_REP) && zero_ok);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match_q <= 1'b0;
      else if (idle_i)
         match_q <= 1'b0;
      else
         match_q <= match_d;
   end

   assign match_o = match_q;
   assign alt_o   = (mode_q.op == OP_ALT) && match_q;
   assign pfx_o   = (mode_q.op == OP_ALT) ? pfx_i
                                          : (match_q || alt_i || (bypass && pfx_i));
   assign loop_o  = mode_q.ge ? match_q : (mode_q.gs ? 1'b0 : loop_i);

endmodule

// File: rtl/rx_elem_chk.sv
module rx_elem_chk
   import rx_cell_pkg::*;
#(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          idle_i,
   input logic          hit_i,
   input logic          pfx_i,
   input logic          loop_i,
   input op_e           op,
   input logic          gs,
   input logic          ge,
   input logic [CW-1:0] cnt_q,
   input logic          match_o,
   input logic          alt_o,
   input logic          loop_o
);

   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_i |=> (!match_o && !alt_o)); // R1

   AST_MATCH_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_i && !hit_i) |=> !match_o); // R2

   AST_CAT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_i && op == OP_CAT && !pfx_i && !(gs && loop_i)) |=> !match_o); // R2

   AST_CNT_CLEAR_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_i && !hit_i) |=> (cnt_q == '0)); // R7

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_i && hit_i && cnt_q == TOP) |=> (cnt_q == TOP)); // R7

   AST_LOOP_END: assert property (@(posedge clk) disable iff (!rst_n)
      ge |-> (loop_o == match_o)); // R9

   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !idle_i |=> $stable(op)); // R10

endmodule

bind rx_elem_cell rx_elem_chk #(.CW(CW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .idle_i  (idle_i),
   .hit_i   (hit_i),
   .pfx_i   (pfx_i),
   .loop_i  (loop_i),
   .op      (mode_q.op),
   .gs      (mode_q.gs),
   .ge      (mode_q.ge),
   .cnt_q   (cnt_q),
   .match_o (match_o),
   .alt_o   (alt_o),
   .loop_o  (loop_o)
);

// File: tb/sim_rx_elem_cell.sv
module sim_rx_elem_cell;

   localparam int CLK_PER = 10;
   localparam int CW      = 8;

   logic          clk = 1'b0;
   logic          rst_n, idle_i, hit_i, pfx_i, loop_i, alt_i;
   logic [2:0]    cfg_op_i;
   logic          cfg_gs_i, cfg_ge_i;
   logic [1:0]    cfg_rk_i;
   logic [CW-1:0] cfg_lo_i, cfg_hi_i;
   logic          match_o, pfx_o, alt_o, loop_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   rx_elem_cell #(.CW(CW), .HAS_REP(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .hit_i(hit_i), .pfx_i(pfx_i),
      .loop_i(loop_i), .alt_i(alt_i), .cfg_op_i(cfg_op_i), .cfg_gs_i(cfg_gs_i),
      .cfg_ge_i(cfg_ge_i), .cfg_rk_i(cfg_rk_i), .cfg_lo_i(cfg_lo_i),
      .cfg_hi_i(cfg_hi_i), .match_o(match_o), .pfx_o(pfx_o), .alt_o(alt_o),
      .loop_o(loop_o)
   );

   task automatic chk(input logic got, input logic exp, input string req);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic load_cfg(input logic [2:0] op, input logic gs, input logic ge,
                           input logic [1:0] rk, input int lo, input int hi);
      cfg_op_i = op; cfg_gs_i = gs; cfg_ge_i = ge; cfg_rk_i = rk;
      cfg_lo_i = CW'(lo); cfg_hi_i = CW'(hi);
      idle_i = 1'b1; hit_i = 1'b0; pfx_i = 1'b0; loop_i = 1'b0; alt_i = 1'b0;
      @(negedge clk);
      idle_i = 1'b0;
   endtask

   task automatic cyc(input logic h, input logic p);
      hit_i = h; pfx_i = p;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(match_o, 1'b0, "R1 match after reset");
      chk(alt_o,   1'b0, "R1 alt after reset");
      load_cfg(3'd3, 0, 0, 0, 0, 0);
      cyc(1, 1);
      chk(match_o, 1'b1, "R1 setup match");
      hit_i = 1'b1; idle_i = 1'b1;
      @(negedge clk);
      idle_i = 1'b0;
      chk(match_o, 1'b0, "R1 idle clears match");
   endtask

   task automatic t_cat;
      load_cfg(3'd0, 0, 0, 0, 0, 0);
      cyc(1, 1); chk(match_o, 1'b1, "R2 hit with prefix");
      cyc(1, 0); chk(match_o, 1'b0, "R2 hit without prefix");
      cyc(0, 1); chk(match_o, 1'b0, "R2 prefix without hit");
   endtask

   task automatic t_plus;
      load_cfg(3'd3, 0, 0, 0, 0, 0);
      cyc(1, 1); chk(match_o, 1'b1, "R3 first");
      cyc(1, 0); chk(match_o, 1'b1, "R3 second");
      cyc(1, 0); chk(match_o, 1'b1, "R3 third");
      cyc(0, 0); chk(match_o, 1'b0, "R3 miss drops");
      cyc(1, 0); chk(match_o, 1'b0, "R3 no restart without prefix");
   endtask

   task automatic t_star;
      load_cfg(3'd2, 0, 0, 0, 0, 0);
      pfx_i = 1'b1; hit_i = 1'b0; #1;
      chk(pfx_o, 1'b1, "R4 bypass with no match");
      @(negedge clk);
      pfx_i = 1'b0; #1;
      chk(pfx_o, 1'b0, "R4 no bypass without prefix");
      cyc(1, 1); chk(match_o, 1'b1, "R4 match");
      cyc(1, 0); chk(match_o, 1'b1, "R4 self extend");
   endtask

   task automatic t_opt;
      load_cfg(3'd4, 0, 0, 0, 0, 0);
      pfx_i = 1'b1; #1;
      chk(pfx_o, 1'b1, "R5 bypass");
      cyc(1, 1); chk(match_o, 1'b1, "R5 single match");
      cyc(1, 0); chk(match_o, 1'b0, "R5 no self extend");
   endtask

   task automatic t_alt;
      load_cfg(3'd1, 0, 0, 0, 0, 0);
      pfx_i = 1'b1; #1;
      chk(pfx_o, 1'b1, "R6 prefix forwarded");
      cyc(1, 1);
      chk(alt_o, 1'b1, "R6 alt carries match");
      pfx_i = 1'b0; hit_i = 1'b0; #1;
      chk(pfx_o, 1'b0, "R6 alt cell pfx_o follows pfx_i only");
      load_cfg(3'd0, 0, 0, 0, 0, 0);
      alt_i = 1'b1; #1;
      chk(pfx_o, 1'b1, "R6 alt_i joins pfx_o");
      chk(alt_o, 1'b0, "R6 non-alt cell alt_o low");
      alt_i = 1'b0;
   endtask

   task automatic t_rep_exact;
      load_cfg(3'd5, 0, 0, 0, 3, 0);
      cyc(1, 1); chk(match_o, 1'b0, "R8 exact count1");
      cyc(1, 0); chk(match_o, 1'b0, "R8 exact count2");
      cyc(1, 0); chk(match_o, 1'b1, "R8 exact count3");
      cyc(1, 0); chk(match_o, 1'b0, "R8 exact count4");
      cyc(0, 0);
      cyc(1, 0); chk(match_o, 1'b0, "R7 miss cleared count");
      cyc(1, 0); chk(match_o, 1'b0, "R7 no self enable after clear");
   endtask

   task automatic t_rep_between;
      load_cfg(3'd5, 0, 0, 3, 2, 4);
      cyc(1, 1); chk(match_o, 1'b0, "R8 between c1");
      cyc(1, 0); chk(match_o, 1'b1, "R8 between c2");
      cyc(1, 0); chk(match_o, 1'b1, "R8 between c3");
      cyc(1, 0); chk(match_o, 1'b1, "R8 between c4");
      cyc(1, 0); chk(match_o, 1'b0, "R8 between c5");
      load_cfg(3'd5, 0, 0, 2, 0, 2);
      pfx_i = 1'b1; #1;
      chk(pfx_o, 1'b1, "R8 atmost zero bypass");
      cyc(1, 1); chk(match_o, 1'b1, "R8 atmost c1");
      cyc(1, 0); chk(match_o, 1'b1, "R8 atmost c2");
      cyc(1, 0); chk(match_o, 1'b0, "R8 atmost c3");
   endtask

   task automatic t_sat;
      load_cfg(3'd5, 0, 0, 1, 255, 0);
      cyc(1, 1);
      for (int i = 2; i <= 254; i++) cyc(1, 0);
      chk(match_o, 1'b0, "R7 count 254 below bound");
      cyc(1, 0); chk(match_o, 1'b1, "R7 count 255");
      for (int i = 0; i < 5; i++) cyc(1, 0);
      chk(match_o, 1'b1, "R7 saturated, no wrap");
   endtask

   task automatic t_group;
      load_cfg(3'd0, 1, 0, 0, 0, 0);
      loop_i = 1'b1; #1;
      chk(loop_o, 1'b0, "R9 start cell loop_o low");
      cyc(1, 0); chk(match_o, 1'b1, "R9 loop enables start cell");
      load_cfg(3'd0, 0, 1, 0, 0, 0);
      cyc(1, 1); #1;
      chk(loop_o, 1'b1, "R9 end cell drives loop");
      cyc(0, 0); #1;
      chk(loop_o, 1'b0, "R9 end cell loop follows match");
      load_cfg(3'd0, 0, 0, 0, 0, 0);
      loop_i = 1'b1; #1;
      chk(loop_o, 1'b1, "R9 interior forwards loop");
      cyc(1, 0); chk(match_o, 1'b0, "R9 interior ignores loop as enable");
      loop_i = 1'b0;
   endtask

   task automatic t_cfg_locked;
      load_cfg(3'd0, 0, 0, 0, 0, 0);
      cfg_op_i = 3'd3; cfg_ge_i = 1'b1;
      cyc(1, 1); chk(match_o, 1'b1, "R10 match");
      cyc(1, 0); chk(match_o, 1'b0, "R10 op change ignored");
      #1;
      chk(loop_o, 1'b0, "R10 flag change ignored");
   endtask

   initial begin
      rst_n = 1'b0; idle_i = 1'b0; hit_i = 1'b0; pfx_i = 1'b0; loop_i = 1'b0;
      alt_i = 1'b0; cfg_op_i = '0; cfg_gs_i = 1'b0; cfg_ge_i = 1'b0;
      cfg_rk_i = '0; cfg_lo_i = '0; cfg_hi_i = '0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cat();
      t_plus();
      t_star();
      t_opt();
      t_alt();
      t_rep_exact();
      t_rep_between();
      t_sat();
      t_group();
      t_cfg_locked();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule